// File: doc/BRIEF.md
# Programmable Vertical Timing Generator

This block produces the vertical blanking and vertical sync levels of a raster display. A vertical counter moves forward on strobes from the horizontal timing logic. Programmable compare values decide on which count each output turns on and on which count it turns off. Software writes three timing words through a small write port: the frame length, the blank window and the sync window. The values are held in a pending copy and move into the working copy only when the counter wraps, so a frame never runs with a mix of old and new settings.

In progressive mode the counter moves once per line, on the line-end strobe. In interlaced mode it moves twice per line, on the mid-line strobe and on the line-end strobe, and a field flag toggles at every wrap. If a field holds an odd number of half-line steps, each field starts on the opposite half of a line from the one before it. The sync edge therefore lands on a mid-line strobe in one field and on a line-end strobe in the next.

Top module: `vtiming_gen`

## Requirements
- R1: After reset, `vcount_o` is 0, `vblank_o` and `vsync_o` are 0, and `field_o` is 0.
- R2: In progressive mode, `vcount_o` rises by one on each `line_end_i` pulse, and a `mid_line_i` pulse leaves it unchanged.
- R3: The frame-length value T (stored minus one) sets the wrap point. A step taken while the count equals T returns the count to 0, so a frame spans T+1 steps.
- R4: The blank window is set by start S and end E, each the count minus one. A step taken from count S makes `vblank_o` 1 from count S+1 onward. A step taken from count E makes it 0. If S equals E, clearing wins.
- R5: The sync window is set by its own start and end and follows the same stepping rule, on `vsync_o`.
- R6: In interlaced mode, both `mid_line_i` and `line_end_i` advance the count by one.
- R7: In interlaced mode, `field_o` toggles at every wrap. In progressive mode, it is 0 after a wrap and stays constant between wraps.
- R8: In interlaced mode with an odd frame length T+1, the strobe that raises `vsync_o` alternates between mid-line and line-end on consecutive fields.
- R9: Writes and changes of `interlace_i` have no effect until the next wrap. The frame in progress keeps its old length and windows.
- R10: `wr_sel_i` selects the register being written: 0 for frame length, 1 for blank, 2 for sync. In the blank and sync words, bits 26:16 hold the end value and bits 10:0 hold the start value. In the frame-length word, bits 10:0 hold T. Bits 31:27 and 15:11 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_end_i | input | 1 | One-cycle strobe at the end of each line |
| mid_line_i | input | 1 | One-cycle strobe at the middle of each line |
| interlace_i | input | 1 | Mode select, 1 for interlaced; takes effect at the next wrap |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Selects the register to write (see R10) |
| wr_data_i | input | 32 | Timing word to write |
| vblank_o | output | 1 | Vertical blank level |
| vsync_o | output | 1 | Vertical sync level |
| vcount_o | output | 11 | Current vertical count |
| field_o | output | 1 | Field indicator |

## Verification
The hardest case to reach is the alternation of the sync-edge phase. It shows up only after several complete interlaced fields, and only when an odd half-line total is combined with a strobe stream whose mid-line and line-end pulses stay in strict alternation. The bench first runs a shortened progressive frame. It then raises the mode input and writes an odd interlaced frame length with the sync and blank words, and keeps feeding alternating strobes until the wrap puts the new settings in force. For each rise of `vsync_o`, the bench records which strobe preceded it and the field flag at that moment. It then compares consecutive records. The deferred-load case is reached the same way: the bench writes a shorter frame in mid-frame and watches the old frame run to its old end.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int unsigned VTG_CW      = 11;
    localparam int unsigned VTG_DW      = 32;
    localparam int unsigned VTG_END_LSB = 16;

    typedef enum logic [1:0] {
        SEL_TOTAL = 2'd0,
        SEL_BLANK = 2'd1,
        SEL_SYNC  = 2'd2
    } vtg_sel_e;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int unsigned CW      = VTG_CW,
    parameter int unsigned DW      = VTG_DW,
    parameter int unsigned END_LSB = VTG_END_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          ilace_i,
    input  logic          load_i,
    output logic [CW-1:0] total_o,
    output logic [CW-1:0] bl_on_o,
    output logic [CW-1:0] bl_off_o,
    output logic [CW-1:0] sy_on_o,
    output logic [CW-1:0] sy_off_o,
    output logic          ilace_o
);
    typedef struct packed {
        logic [CW-1:0] total;
        logic [CW-1:0] bl_on;
        logic [CW-1:0] bl_off;
        logic [CW-1:0] sy_on;
        logic [CW-1:0] sy_off;
        logic          ilace;
    } cfg_t;

    typedef struct packed {
        cfg_t pend;
        cfg_t act;
    } regs_t;

    regs_t d, q;
    logic [CW-1:0] lo_field, hi_field;
    logic          unused_bits;

    assign lo_field    = wr_data_i[CW-1:0];
    assign hi_field    = wr_data_i[END_LSB +: CW];
    assign unused_bits = ^{wr_data_i[DW-1:END_LSB+CW], wr_data_i[END_LSB-1:CW]};

    always_comb begin
        d = q;
        d.pend.ilace = ilace_i;
        if (wr_en_i) begin
            unique case (vtg_sel_e'(wr_sel_i))
                SEL_TOTAL: d.pend.total = lo_field;
                SEL_BLANK: begin
                    d.pend.bl_on  = lo_field;
                    d.pend.bl_off = hi_field;
                end
                SEL_SYNC: begin
                    d.pend.sy_on  = lo_field;
                    d.pend.sy_off = hi_field;
                end
                default: ;
            endcase
        end
        if (load_i) begin
            d.act = q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign total_o  = q.act.total;
    assign bl_on_o  = q.act.bl_on;
    assign bl_off_o = q.act.bl_off;
    assign sy_on_o  = q.act.sy_on;
    assign sy_off_o = q.act.sy_off;
    assign ilace_o  = q.act.ilace;

    // R9: working copy only changes at a frame boundary
    p_act_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q.act));
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
    import vtg_pkg::*;
#(
    parameter int unsigned CW = VTG_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          ilace_i,
    input  logic [CW-1:0] total_i,
    output logic [CW-1:0] count_o,
    output logic          field_o,
    output logic          wrap_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          field;
    } cnt_t;

    cnt_t d, q;
    logic at_end;

    assign at_end = (q.cnt == total_i);
    assign wrap_o = adv_i && at_end;

    always_comb begin
        d = q;
        if (adv_i) begin
            if (at_end) begin
                d.cnt   = '0;
                d.field = ilace_i ? !q.field : 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count_o = q.cnt;
    assign field_o = q.field;

    // R2: count holds without a step
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(count_o));
    // R3: a step at the wrap point returns to zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_o == '0));
    // R3: count never passes the frame length
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= total_i);
    // R7: field only moves on a wrap
    p_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> $stable(field_o));
endmodule

// File: rtl/vtg_edge.sv
module vtg_edge
    import vtg_pkg::*;
#(
    parameter int unsigned CW = VTG_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] on_i,
    input  logic [CW-1:0] off_i,
    output logic          flag_o
);
    typedef struct packed {
        logic flag;
    } edge_t;

    edge_t d, q;

    always_comb begin
        d = q;
        if (adv_i) begin
            if (count_i == on_i)  d.flag = 1'b1;
            if (count_i == off_i) d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag_o = q.flag;

    // R4 / R5: level only moves on a counter step
    p_step_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(flag_o));
    // R4 / R5: a step from the end value always clears
    p_off_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && count_i == off_i) |=> !flag_o);
endmodule

// File: rtl/vtiming_gen.sv
module vtiming_gen
    import vtg_pkg::*;
#(
    parameter int unsigned CW      = VTG_CW,
    parameter int unsigned DW      = VTG_DW,
    parameter int unsigned END_LSB = VTG_END_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end_i,
    input  logic          mid_line_i,
    input  logic          interlace_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          vblank_o,
    output logic          vsync_o,
    output logic [CW-1:0] vcount_o,
    output logic          field_o
);
    localparam int unsigned N_EDGE = 2;

    logic          ilace_act, adv, wrap;
    logic [CW-1:0] total;
    logic [CW-1:0] on_v  [N_EDGE];
    logic [CW-1:0] off_v [N_EDGE];
    logic [N_EDGE-1:0] flag;

    assign adv = line_end_i || (ilace_act && mid_line_i);

    vtg_regs #(.CW(CW), .DW(DW), .END_LSB(END_LSB)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .wr_data_i(wr_data_i),
        .ilace_i  (interlace_i),
        .load_i   (wrap),
        .total_o  (total),
        .bl_on_o  (on_v[0]),
        .bl_off_o (off_v[0]),
        .sy_on_o  (on_v[1]),
        .sy_off_o (off_v[1]),
        .ilace_o  (ilace_act)
    );

    vtg_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv),
        .ilace_i(ilace_act),
        .total_i(total),
        .count_o(vcount_o),
        .field_o(field_o),
        .wrap_o (wrap)
    );

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        vtg_edge #(.CW(CW)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (adv),
            .count_i(vcount_o),
            .on_i   (on_v[g]),
            .off_i  (off_v[g]),
            .flag_o (flag[g])
        );
    end

    assign vblank_o = flag[0];
    assign vsync_o  = flag[1];

    // R2: lone mid-line strobe is ignored in progressive mode
    p_prog_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ilace_act && mid_line_i && !line_end_i) |=> $stable(vcount_o));
    // R6: in interlaced mode a lone mid-line strobe moves the count
    p_ilace_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ilace_act && mid_line_i && !line_end_i) |=> !$stable(vcount_o));
endmodule

// File: tb/vtiming_gen_tb_top.sv
module vtiming_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_end_i = 1'b0, mid_line_i = 1'b0, interlace_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd0;
    logic [31:0] wr_data_i = '0;
    logic        vblank_o, vsync_o, field_o;
    logic [10:0] vcount_o;

    int total = 0, bad = 0;
    bit done = 1'b0;
    int nrise = 0;
    bit rise_mid [8];
    bit rise_fld [8];

    always #10 clk = !clk;

    vtiming_gen dut_i (
        .clk(clk), .rst_n(rst_n), .line_end_i(line_end_i), .mid_line_i(mid_line_i),
        .interlace_i(interlace_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .vblank_o(vblank_o), .vsync_o(vsync_o),
        .vcount_o(vcount_o), .field_o(field_o)
    );

    // {mid pulse first, expected count, expected blank, expected sync}
    localparam logic [13:0] VEC [12] = '{
        {1'b0, 11'd1, 1'b0, 1'b0}, {1'b1, 11'd2, 1'b0, 1'b0},
        {1'b0, 11'd3, 1'b0, 1'b0}, {1'b1, 11'd4, 1'b0, 1'b0},
        {1'b1, 11'd5, 1'b0, 1'b0}, {1'b0, 11'd6, 1'b0, 1'b0},
        {1'b1, 11'd7, 1'b1, 1'b0}, {1'b0, 11'd8, 1'b1, 1'b1},
        {1'b1, 11'd9, 1'b1, 1'b0}, {1'b0, 11'd0, 1'b0, 1'b0},
        {1'b1, 11'd1, 1'b0, 1'b0}, {1'b0, 11'd2, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit is_mid);
        logic pre;
        pre = vsync_o;
        @(negedge clk);
        if (is_mid) mid_line_i = 1'b1;
        else        line_end_i = 1'b1;
        @(negedge clk);
        mid_line_i = 1'b0;
        line_end_i = 1'b0;
        if (!pre && vsync_o && nrise < 8) begin
            rise_mid[nrise] = is_mid;
            rise_fld[nrise] = field_o;
            nrise++;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", vcount_o, 0);
        chk("R1 blank", vblank_o, 0);
        chk("R1 sync", vsync_o, 0);
        chk("R1 field", field_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: progressive setup, total 9, blank 6..9, sync 7..8
        wr(2'd0, 32'h0000_0009);
        wr(2'd1, 32'h0009_0006);
        wr(2'd2, 32'h0008_0007);
        pulse(1'b0);
        chk("R3 prime wrap", vcount_o, 0);

        // R2 R3 R4 R5: table walk
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][13]) begin
                pulse(1'b1);
                chk("R2 mid ignored", vcount_o, (VEC[i][12:2] == 0) ? 9 : VEC[i][12:2] - 1);
            end
            pulse(1'b0);
            chk("R2 R3 count", vcount_o, VEC[i][12:2]);
            chk("R4 blank", vblank_o, VEC[i][1]);
            chk("R5 sync", vsync_o, VEC[i][0]);
            chk("R7 prog field", field_o, 0);
        end

        // R9 R10: mid-frame writes at count 2, reserved bits set
        wr(2'd0, 32'hF800_F804);
        wr(2'd1, 32'hF804_F802);
        wr(2'd2, 32'h0001_0000);
        pulse(1'b0);
        chk("R9 old blank", vblank_o, 0);
        for (int i = 0; i < 6; i++) pulse(1'b0);
        chk("R9 old length", vcount_o, 9);
        chk("R9 old blank window", vblank_o, 1);
        pulse(1'b0);
        chk("R3 wrap", vcount_o, 0);
        pulse(1'b0);
        chk("R5 new sync on", vsync_o, 1);
        pulse(1'b0);
        chk("R5 new sync off", vsync_o, 0);
        pulse(1'b0);
        chk("R4 new blank on", vblank_o, 1);
        pulse(1'b0);
        chk("R10 total field", vcount_o, 4);
        pulse(1'b0);
        chk("R10 reserved ignored wrap", vcount_o, 0);
        chk("R4 new blank off", vblank_o, 0);

        // R6 R7 R8: interlaced, total 8 (odd: 9 steps), sync 2..3, blank 6..8
        interlace_i = 1'b1;
        wr(2'd0, 32'h0000_0008);
        wr(2'd1, 32'h0008_0006);
        wr(2'd2, 32'h0003_0002);
        for (int i = 0; i < 5; i++) begin
            pulse(1'b1);
            pulse(1'b0);
        end
        chk("R9 mode at wrap count", vcount_o, 0);
        chk("R7 prog wrap field", field_o, 0);
        nrise = 0;
        pulse(1'b1);
        chk("R6 mid advances", vcount_o, 1);
        for (int i = 1; i < 36; i++) pulse(i % 2 == 0);
        chk("R3 four fields end", vcount_o, 0);
        chk("R7 field after four wraps", field_o, 0);
        chk("R8 rise count", nrise, 4);
        chk("R8 first rise on mid", rise_mid[0], 1);
        chk("R7 first field", rise_fld[0], 0);
        for (int k = 1; k < 4; k++) begin
            chk("R8 strobe alternates", rise_mid[k], !rise_mid[k-1]);
            chk("R7 field alternates", rise_fld[k], !rise_fld[k-1]);
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule